// File: doc/BRIEF.md
# Receive Error Status Collector

This block gathers the per-frame error indications raised while a frame is being received. Its sources are the line-side error pulses (CRC, alignment, symbol, sequence, carrier extension and the physical-layer data error) and the checksum offload results. Each checksum source comes as an "error" pulse plus a "was checked" pulse. Events are held in sticky flags from the time the packet becomes active until its end-of-packet pulse.

One cycle after end of packet, the block presents an 8-bit error byte for the descriptor writeback, together with end-of-packet and descriptor-done qualifiers. Three configuration bits gate what is reported: IP checksum offload enable, TCP/UDP checksum offload enable, and store-bad-packets. A drop-request output tells the receive filter to discard a frame with a line error when bad-packet storage is off. Checksum failures never cause a drop.

Top module: `rxerr_collect`

## Requirements
- R1: A CRC error and an alignment error both set error bit 0, and the byte gives no way to tell them apart.
- R2: A symbol error sets bit 1, a sequence error sets bit 2 and a carrier extension error sets bit 4. Bit 3 is always 0.
- R3: Bit 5 (TCP/UDP checksum error) is 1 only if a TCP/UDP checksum failure and a TCP/UDP "checked" indication both occurred in the packet and TCP/UDP offload enable (cfg bit 0) is 1.
- R4: Bit 6 (IP checksum error) is 1 only if an IP checksum failure and an IP "checked" indication both occurred in the packet and IP offload enable (cfg bit 1) is 1.
- R5: Bit 7 (physical-layer data error) is 1 only if such an error occurred and store-bad-packets (cfg bit 2) is 1.
- R6: `wb_stb`, `wb_eop` and `wb_dd` go high for exactly one cycle, in the cycle after the `eop` input. `wb_err` and `wb_drop` are 0 in every other cycle.
- R7: Events seen in any cycle with `pkt_act` high, or in the `eop` cycle itself, accumulate sticky for the packet. They are cleared by the writeback, so the next packet starts with no errors.
- R8: Event pulses in a cycle with both `pkt_act` and `eop` low have no effect on any later error byte.
- R9: `wb_drop` is 1 with the strobe when any of bits 0, 1, 2 or 4 is set and store-bad-packets is 0. Checksum and physical-layer data errors alone never assert it.
- R10: While `rst` is high, and in the cycle after it, all outputs are 0 and the accumulated events are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_act | input | 1 | Packet reception in progress |
| eop | input | 1 | End-of-packet pulse |
| crc_err | input | 1 | CRC error pulse |
| align_err | input | 1 | Alignment error pulse |
| sym_err | input | 1 | Symbol error pulse |
| seq_err | input | 1 | Sequence error pulse |
| cext_err | input | 1 | Carrier extension error pulse |
| phy_err | input | 1 | Physical-layer data error pulse |
| ip_ck_bad | input | 1 | IP checksum failure pulse |
| ip_ck_done | input | 1 | IP checksum was checked |
| l4_ck_bad | input | 1 | TCP/UDP checksum failure pulse |
| l4_ck_done | input | 1 | TCP/UDP checksum was checked |
| cfg | input | 3 | {store_bad, ip_en, l4_en}, sampled in the eop cycle |
| wb_stb | output | 1 | Writeback strobe |
| wb_eop | output | 1 | End-of-packet qualifier |
| wb_dd | output | 1 | Descriptor-done qualifier |
| wb_err | output | 8 | Error byte |
| wb_drop | output | 1 | Drop request to the filter |

## Verification
Every result comes out of a single output register: the error byte, the qualifiers and the drop request are all due in the cycle after the `eop` input, and are sampled on the falling edge that follows that rising edge. Inputs change only on falling edges. The bench therefore reads each writeback exactly one rising edge after it raises `eop`, and one cycle later confirms that the strobe has dropped. The ignored-event and clear-after-writeback cases are observed through the error byte of an empty packet that follows them.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
  localparam int EV_N   = 10;
  localparam int EV_CRC = 0;
  localparam int EV_ALN = 1;
  localparam int EV_SYM = 2;
  localparam int EV_SEQ = 3;
  localparam int EV_CXT = 4;
  localparam int EV_PHY = 5;
  localparam int EV_IPB = 6;
  localparam int EV_IPC = 7;
  localparam int EV_L4B = 8;
  localparam int EV_L4C = 9;

  localparam int ERR_W  = 8;
  localparam int B_CRC  = 0;
  localparam int B_SYM  = 1;
  localparam int B_SEQ  = 2;
  localparam int B_RSV  = 3;
  localparam int B_CXT  = 4;
  localparam int B_L4   = 5;
  localparam int B_IP   = 6;
  localparam int B_PHY  = 7;

  typedef struct packed {
    logic store_bad;
    logic ip_en;
    logic l4_en;
  } rxerr_cfg_t;
endpackage

// File: rtl/rxerr_accum.sv
module rxerr_accum #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         act,
  input  logic         eop,
  input  logic [W-1:0] ev,
  output logic [W-1:0] merged
);
  logic [W-1:0] flags;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || eop)
        flags[i] <= 1'b0;
      else if (act && ev[i])
        flags[i] <= 1'b1;
    end
    assign merged[i] = flags[i] | ev[i];
  end
endmodule

// File: rtl/rxerr_compose.sv
module rxerr_compose
  import rxerr_pkg::*;
(
  input  logic [EV_N-1:0]  ev,
  input  rxerr_cfg_t       cfg,
  output logic [ERR_W-1:0] err,
  output logic             drop
);
  always_comb begin
    err        = '0;
    err[B_CRC] = ev[EV_CRC] | ev[EV_ALN];
    err[B_SYM] = ev[EV_SYM];
    err[B_SEQ] = ev[EV_SEQ];
    err[B_RSV] = 1'b0;
    err[B_CXT] = ev[EV_CXT];
    err[B_L4]  = ev[EV_L4B] & ev[EV_L4C] & cfg.l4_en;
    err[B_IP]  = ev[EV_IPB] & ev[EV_IPC] & cfg.ip_en;
    err[B_PHY] = ev[EV_PHY] & cfg.store_bad;
    drop       = (err[B_CRC] | err[B_SYM] | err[B_SEQ] | err[B_CXT])
                 & ~cfg.store_bad;
  end
endmodule

// File: rtl/rxerr_collect.sv
module rxerr_collect
  import rxerr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pkt_act,
  input  logic       eop,
  input  logic       crc_err,
  input  logic       align_err,
  input  logic       sym_err,
  input  logic       seq_err,
  input  logic       cext_err,
  input  logic       phy_err,
  input  logic       ip_ck_bad,
  input  logic       ip_ck_done,
  input  logic       l4_ck_bad,
  input  logic       l4_ck_done,
  input  logic [2:0] cfg,
  output logic       wb_stb,
  output logic       wb_eop,
  output logic       wb_dd,
  output logic [7:0] wb_err,
  output logic       wb_drop
);
  logic [EV_N-1:0]  ev_now;
  logic [EV_N-1:0]  ev_all;
  logic [ERR_W-1:0] err_c;
  logic             drop_c;
  rxerr_cfg_t       cfg_s;

  assign cfg_s = rxerr_cfg_t'(cfg);

  always_comb begin
    ev_now         = '0;
    ev_now[EV_CRC] = crc_err;
    ev_now[EV_ALN] = align_err;
    ev_now[EV_SYM] = sym_err;
    ev_now[EV_SEQ] = seq_err;
    ev_now[EV_CXT] = cext_err;
    ev_now[EV_PHY] = phy_err;
    ev_now[EV_IPB] = ip_ck_bad;
    ev_now[EV_IPC] = ip_ck_done;
    ev_now[EV_L4B] = l4_ck_bad;
    ev_now[EV_L4C] = l4_ck_done;
  end

  rxerr_accum #(.W(EV_N)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .act    (pkt_act),
    .eop    (eop),
    .ev     (ev_now),
    .merged (ev_all)
  );

  rxerr_compose u_cmp (
    .ev   (ev_all),
    .cfg  (cfg_s),
    .err  (err_c),
    .drop (drop_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_stb  <= 1'b0;
      wb_eop  <= 1'b0;
      wb_dd   <= 1'b0;
      wb_err  <= '0;
      wb_drop <= 1'b0;
    end else begin
      wb_stb  <= eop;
      wb_eop  <= eop;
      wb_dd   <= eop;
      wb_err  <= eop ? err_c : '0;
      wb_drop <= eop & drop_c;
    end
  end
endmodule

// File: rtl/rxerr_collect_chk.sv
module rxerr_collect_chk (
  input logic       clk,
  input logic       rst,
  input logic       eop,
  input logic [2:0] cfg,
  input logic       wb_stb,
  input logic       wb_eop,
  input logic       wb_dd,
  input logic [7:0] wb_err,
  input logic       wb_drop
);
  a_r6_stb_follows_eop: assert property (@(posedge clk) disable iff (rst)
    eop |=> (wb_stb && wb_eop && wb_dd));
  a_r6_no_stb_without_eop: assert property (@(posedge clk) disable iff (rst)
    !eop |=> !wb_stb);
  a_r6_quiet_outputs: assert property (@(posedge clk) disable iff (rst)
    !wb_stb |-> (wb_err == 8'h00 && !wb_drop));
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    wb_err[3] == 1'b0);
  a_r3_l4_gated: assert property (@(posedge clk) disable iff (rst)
    wb_err[5] |-> $past(cfg[0]));
  a_r4_ip_gated: assert property (@(posedge clk) disable iff (rst)
    wb_err[6] |-> $past(cfg[1]));
  a_r5_phy_gated: assert property (@(posedge clk) disable iff (rst)
    wb_err[7] |-> $past(cfg[2]));
  a_r9_drop_cause: assert property (@(posedge clk) disable iff (rst)
    wb_drop |-> ((wb_err[0] || wb_err[1] || wb_err[2] || wb_err[4]) && !$past(cfg[2])));
endmodule

bind rxerr_collect rxerr_collect_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .eop     (eop),
  .cfg     (cfg),
  .wb_stb  (wb_stb),
  .wb_eop  (wb_eop),
  .wb_dd   (wb_dd),
  .wb_err  (wb_err),
  .wb_drop (wb_drop)
);

// File: tb/sim_rxerr_collect.sv
module sim_rxerr_collect;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pkt_act = 1'b0, eop = 1'b0;
  logic [9:0] ev = '0;
  logic [2:0] cfg = '0;
  logic wb_stb, wb_eop, wb_dd, wb_drop;
  logic [7:0] wb_err;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rxerr_collect u0 (
    .clk(clk), .rst(rst), .pkt_act(pkt_act), .eop(eop),
    .crc_err(ev[0]), .align_err(ev[1]), .sym_err(ev[2]), .seq_err(ev[3]),
    .cext_err(ev[4]), .phy_err(ev[5]), .ip_ck_bad(ev[6]), .ip_ck_done(ev[7]),
    .l4_ck_bad(ev[8]), .l4_ck_done(ev[9]), .cfg(cfg),
    .wb_stb(wb_stb), .wb_eop(wb_eop), .wb_dd(wb_dd),
    .wb_err(wb_err), .wb_drop(wb_drop)
  );

  // Event bits: 0 crc,1 align,2 sym,3 seq,4 cext,5 phy,6 ip_bad,7 ip_chk,8 l4_bad,9 l4_chk
  // cfg: {store_bad, ip_en, l4_en}; vector = {ev[9:0], cfg[2:0], err[7:0], drop}
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {10'h000, 3'b011, 8'h00, 1'b0},  // R6 clean frame
    {10'h001, 3'b011, 8'h01, 1'b1},  // R1 crc
    {10'h002, 3'b011, 8'h01, 1'b1},  // R1 alignment
    {10'h01C, 3'b011, 8'h16, 1'b1},  // R2 sym seq cext
    {10'h300, 3'b011, 8'h20, 1'b0},  // R3 R9 l4 checksum
    {10'h100, 3'b011, 8'h00, 1'b0},  // R3 not checked
    {10'h300, 3'b010, 8'h00, 1'b0},  // R3 offload off
    {10'h0C0, 3'b011, 8'h40, 1'b0},  // R4 ip checksum
    {10'h0C0, 3'b001, 8'h00, 1'b0},  // R4 offload off
    {10'h020, 3'b011, 8'h00, 1'b0},  // R5 phy, no store
    {10'h020, 3'b111, 8'h80, 1'b0},  // R5 phy, store
    {10'h021, 3'b111, 8'h81, 1'b0},  // R9 store suppresses drop
    {10'h3FF, 3'b111, 8'hF7, 1'b0},  // R2 all, store
    {10'h3FF, 3'b011, 8'h77, 1'b1}   // R9 all, no store
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drives one packet: events in the middle cycle, optional events on the eop cycle.
  task automatic run_pkt(input logic [9:0] mid, input logic [9:0] at_eop, input logic [2:0] c);
    @(negedge clk); pkt_act = 1'b1; cfg = c;
    @(negedge clk); ev = mid;
    @(negedge clk); ev = '0;
    @(negedge clk); eop = 1'b1; ev = at_eop;
    @(negedge clk); eop = 1'b0; pkt_act = 1'b0; ev = '0;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 stb in reset", {7'd0, wb_stb}, 8'h00);
    chk("R10 err in reset", wb_err, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 outputs after reset", {4'd0, wb_stb, wb_eop, wb_dd, wb_drop}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      run_pkt(VEC[i][21:12], 10'h000, VEC[i][11:9]);
      chk($sformatf("R6 qualifiers v%0d", i), {5'd0, wb_stb, wb_eop, wb_dd}, 8'h07);
      chk($sformatf("R1-5 err v%0d", i), wb_err, VEC[i][8:1]);
      chk($sformatf("R9 drop v%0d", i), {7'd0, wb_drop}, {7'd0, VEC[i][0]});
      @(negedge clk);
      chk($sformatf("R6 single cycle v%0d", i), {5'd0, wb_stb, wb_eop, wb_dd}, 8'h00);
      chk($sformatf("R6 quiet err v%0d", i), {wb_err[7:1], wb_drop}, 8'h00);
    end

    // R8: pulses while idle are ignored
    @(negedge clk); ev = 10'h3FF; cfg = 3'b111;
    @(negedge clk); ev = '0;
    run_pkt(10'h000, 10'h000, 3'b111);
    chk("R8 idle events ignored", wb_err, 8'h00);

    // R7: event on the eop cycle itself counts
    run_pkt(10'h000, 10'h004, 3'b011);
    chk("R7 eop-cycle event", wb_err, 8'h02);

    // R7: events on separate cycles accumulate
    @(negedge clk); pkt_act = 1'b1; cfg = 3'b011;
    @(negedge clk); ev = 10'h008;
    @(negedge clk); ev = 10'h000;
    @(negedge clk); ev = 10'h200;
    @(negedge clk); ev = 10'h100;
    @(negedge clk); ev = 10'h000;
    repeat (5) @(negedge clk);
    eop = 1'b1;
    @(negedge clk); eop = 1'b0; pkt_act = 1'b0;
    chk("R7 sticky accumulation", wb_err, 8'h24);

    // R7: next packet starts clean
    run_pkt(10'h000, 10'h000, 3'b011);
    chk("R7 cleared after writeback", wb_err, 8'h00);
    chk("R7 no drop after clear", {7'd0, wb_drop}, 8'h00);

    // R10: reset in mid-packet clears accumulated events
    @(negedge clk); pkt_act = 1'b1; ev = 10'h001;
    @(negedge clk); ev = '0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk); eop = 1'b1;
    @(negedge clk); eop = 1'b0; pkt_act = 1'b0;
    chk("R10 reset clears events", wb_err, 8'h00);
    chk("R10 stb after reset packet", {7'd0, wb_stb}, 8'h01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule